// File: doc/BRIEF.md
# Programmable Clock Channel Divider

This block divides one output channel's clock. The high phase and the low phase each have their own cycle count, so one configuration sets both the divide ratio and the duty cycle. A high count of N gives N + 1 input cycles high. A low count of M gives M + 1 input cycles low. The output period is N + M + 2 input cycles. An even ratio with M = N gives a 50% duty cycle. An odd ratio uses M = N + 1, which makes the low phase one cycle longer than the high phase.

A channel can be shifted against its neighbours by a coarse delay counted in input rising edges. An optional low-lead bit adds one full low phase ahead of the first high phase. Neither takes effect until a synchronisation request is released. While the request is held, the output stays low and all counting stops. Changes to the high and low counts made during normal running are picked up at the start of the next period, so the output never shows a shortened pulse. A bypass input routes the input clock straight to the output.

Top module: `chdiv_top`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0 (with bypass off).
- R2: In steady running, `clk_out` is high for `cfg_high`+1 input cycles, then low for `cfg_low`+1 input cycles, giving a period of `cfg_high`+`cfg_low`+2 input cycles.
- R3: With `cfg_low` equal to `cfg_high`, the high and low phases have the same length (50% duty cycle).
- R4: With `cfg_low` = `cfg_high`+1, the low phase is exactly one input cycle longer than the high phase.
- R5: A rising edge that samples `sync_req` = 1 drives `clk_out` low after that edge, and the output stays low while the request is held.
- R6: Let E0 be the first rising edge that samples `sync_req` = 0 after the request was held. With `cfg_low_lead` = 0, `clk_out` first goes high after edge E0 + `cfg_offset`.
- R7: With `cfg_low_lead` = 1, one low phase of `cfg_low`+1 cycles is inserted before the first high phase, so `clk_out` first goes high after edge E0 + `cfg_offset` + `cfg_low` + 1.
- R8: A change to `cfg_offset` or `cfg_low_lead` while running, with no new synchronisation, has no effect on `clk_out`.
- R9: A change to `cfg_high` or `cfg_low` while running takes effect only at the next rising edge of `clk_out` (the period boundary). The current period completes unchanged.
- R10: With `cfg_bypass` = 1, `clk_out` equals `clk_in`, high while the input is high and low while it is low.
- R11: The extreme counts work. With both counts at 0 the block divides by 2, and with both at 15 it divides by 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Divider input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_req | input | 1 | Synchronisation request; holds the output low, release restarts counting |
| cfg_high | input | 4 | High count N (high phase lasts N+1 cycles) |
| cfg_low | input | 4 | Low count M (low phase lasts M+1 cycles) |
| cfg_offset | input | 4 | Coarse delay in input edges, applied on sync release |
| cfg_low_lead | input | 1 | 1: run a low phase before the first high phase after sync |
| cfg_bypass | input | 1 | 1: route the input clock directly to the output |
| clk_out | output | 1 | Divided clock |

## Verification
The bench uses the default 4-bit count width. At this width the shortest period (2 cycles) and the longest period (32 cycles) can both be reached within a few hundred cycles, and so can the largest offset of 15 edges plus a 16-cycle lead phase. Every 4-bit value is reachable, so the test cases cover the wrap of the down-counter at zero, changes to the counts in the middle of a period, and offset changes that must be ignored. A narrower width would not reach the same edge cases as the real field size.

// File: rtl/chdiv_pkg.sv
package chdiv_pkg;
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_DELAY = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } phase_e;
endpackage

// File: rtl/chdiv_snap.sv
module chdiv_snap #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_sync,
  input  logic             load_period,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic             cfg_low_lead,
  output logic [CNT_W-1:0] high_q,
  output logic [CNT_W-1:0] low_q,
  output logic             lead_q
);
  logic             cnt_en;
  logic [CNT_W-1:0] high_d;
  logic [CNT_W-1:0] low_d;
  logic             lead_d;

  always_comb begin
    cnt_en = load_sync | load_period;
    high_d = cnt_en ? cfg_high : high_q;
    low_d  = cnt_en ? cfg_low  : low_q;
    lead_d = load_sync ? cfg_low_lead : lead_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high_q <= '0;
      low_q  <= '0;
      lead_q <= 1'b0;
    end else begin
      high_q <= high_d;
      low_q  <= low_d;
      lead_q <= lead_d;
    end
  end
endmodule

// File: rtl/chdiv_seq.sv
module chdiv_seq
  import chdiv_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_offset,
  input  logic             cfg_low_lead,
  input  logic [CNT_W-1:0] low_q,
  input  logic             lead_q,
  output logic             load_sync,
  output logic             load_period,
  output logic             div_q
);
  phase_e           phase_q, phase_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    phase_nx    = phase_q;
    cnt_nx      = cnt_q;
    load_sync   = 1'b0;
    load_period = 1'b0;
    if (sync_req) begin
      phase_nx = PH_HOLD;
      cnt_nx   = '0;
    end else begin
      unique case (phase_q)
        PH_HOLD: begin
          load_sync = 1'b1;
          if (cfg_offset != '0) begin
            phase_nx = PH_DELAY;
            cnt_nx   = cfg_offset - 1'b1;
          end else if (cfg_low_lead) begin
            phase_nx = PH_LOW;
            cnt_nx   = cfg_low;
          end else begin
            phase_nx    = PH_HIGH;
            cnt_nx      = cfg_high;
            load_period = 1'b1;
          end
        end
        PH_DELAY: begin
          if (cnt_q != '0) begin
            cnt_nx = cnt_q - 1'b1;
          end else if (lead_q) begin
            phase_nx = PH_LOW;
            cnt_nx   = low_q;
          end else begin
            phase_nx    = PH_HIGH;
            cnt_nx      = cfg_high;
            load_period = 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q != '0) begin
            cnt_nx = cnt_q - 1'b1;
          end else begin
            phase_nx = PH_LOW;
            cnt_nx   = low_q;
          end
        end
        PH_LOW: begin
          if (cnt_q != '0) begin
            cnt_nx = cnt_q - 1'b1;
          end else begin
            phase_nx    = PH_HIGH;
            cnt_nx      = cfg_high;
            load_period = 1'b1;
          end
        end
        default: begin
          phase_nx = PH_HOLD;
          cnt_nx   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HOLD;
      cnt_q   <= '0;
      div_q   <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      cnt_q   <= cnt_nx;
      div_q   <= (phase_nx == PH_HIGH);
    end
  end

  // R5
  sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |=> !div_q);

  // R2
  fall_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q && !sync_req) |=> (div_q || phase_q == PH_LOW));
endmodule

// File: rtl/chdiv_top.sv
module chdiv_top #(
  parameter int CNT_W = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             sync_req,
  input  logic [CNT_W-1:0] cfg_high,
  input  logic [CNT_W-1:0] cfg_low,
  input  logic [CNT_W-1:0] cfg_offset,
  input  logic             cfg_low_lead,
  input  logic             cfg_bypass,
  output logic             clk_out
);
  localparam int RUN_W = CNT_W + 1;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             load_sync, load_period, div_q;
  logic [CNT_W-1:0] high_q, low_q;
  logic             lead_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  chdiv_snap #(.CNT_W(CNT_W)) snap_i (
    .clk(clk_in), .rst_n(rst_int_n),
    .load_sync(load_sync), .load_period(load_period),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_low_lead(cfg_low_lead),
    .high_q(high_q), .low_q(low_q), .lead_q(lead_q)
  );

  chdiv_seq #(.CNT_W(CNT_W)) seq_i (
    .clk(clk_in), .rst_n(rst_int_n), .sync_req(sync_req),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_offset(cfg_offset),
    .cfg_low_lead(cfg_low_lead), .low_q(low_q), .lead_q(lead_q),
    .load_sync(load_sync), .load_period(load_period), .div_q(div_q)
  );

  assign clk_out = cfg_bypass ? clk_in : div_q;

  // Run-length counters that exist only to support the checks below
  logic [RUN_W-1:0] hi_run, lo_run;
  logic             run_ok;

  always_ff @(posedge clk_in or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_run <= '0;
      lo_run <= '0;
      run_ok <= 1'b0;
    end else begin
      hi_run <= div_q ? hi_run + 1'b1 : '0;
      lo_run <= div_q ? '0 : lo_run + 1'b1;
      run_ok <= sync_req ? 1'b0 : (run_ok | div_q);
    end
  end

  // R2
  high_len_chk: assert property (@(posedge clk_in) disable iff (!rst_int_n)
    ($fell(div_q) && !$past(sync_req)) |-> (hi_run == {1'b0, high_q} + 1'b1));

  // R9
  low_len_chk: assert property (@(posedge clk_in) disable iff (!rst_int_n)
    ($rose(div_q) && run_ok) |-> (lo_run == {1'b0, $past(low_q)} + 1'b1));
endmodule

// File: tb/chdiv_top_tb_top.sv
module chdiv_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, sync_req, cfg_low_lead, cfg_bypass;
  logic [3:0] cfg_high, cfg_low, cfg_offset;
  logic       clk_out;

  always #2 clk = ~clk;

  chdiv_top #(.CNT_W(4)) dut_i (
    .clk_in(clk), .rst_n(rst_n), .sync_req(sync_req),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_offset(cfg_offset),
    .cfg_low_lead(cfg_low_lead), .cfg_bypass(cfg_bypass), .clk_out(clk_out)
  );

  typedef struct { logic v; string tag; } exp_t;
  exp_t q[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  // Monitor: one expected item per rising edge, sampled 1 ns after it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        tests++;
        if (clk_out !== e.v) begin
          fails++;
          $display("FAIL %s: clk_out=%0b expected %0b at %0t", e.tag, clk_out, e.v, $time);
        end
      end
    end
  end

  task automatic chk(logic act, logic exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clk_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Push the value expected after the next rising edge, then move to the next falling edge
  task automatic tick(logic v, string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic run_case(string tag, int n, int m, int po, int ll, int cycles,
                          int chg_at, int n2, int m2, int po2, int ll2);
    int d, pos, nc, mc;
    logic e;
    cfg_high = 4'(n); cfg_low = 4'(m); cfg_offset = 4'(po); cfg_low_lead = ll[0];
    sync_req = 1'b1;
    repeat (3) tick(1'b0, "R5");
    sync_req = 1'b0;
    d = po + ((ll != 0) ? m + 1 : 0);
    pos = 0; nc = n; mc = m;
    for (int j = 0; j < cycles; j++) begin
      if (j == chg_at) begin
        cfg_high = 4'(n2); cfg_low = 4'(m2); cfg_offset = 4'(po2); cfg_low_lead = ll2[0];
      end
      if (j < d) begin
        e = 1'b0;
      end else begin
        if (pos == 0) begin
          nc = int'(cfg_high);
          mc = int'(cfg_low);
        end
        e = (pos <= nc);
        pos++;
        if (pos == nc + mc + 2) pos = 0;
      end
      tick(e, tag);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sync_req = 1'b1; cfg_bypass = 1'b0;
    cfg_high = 4'd0; cfg_low = 4'd0; cfg_offset = 4'd0; cfg_low_lead = 1'b0;
    #9;
    chk(clk_out, 1'b0, "R1");
    @(negedge clk);
    chk(clk_out, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    run_case("R3", 3, 3, 0, 0, 60, -1, 0, 0, 0, 0);
    run_case("R4", 2, 3, 0, 0, 60, -1, 0, 0, 0, 0);
    run_case("R2", 1, 4, 0, 0, 40, -1, 0, 0, 0, 0);
    run_case("R11", 0, 0, 0, 0, 30, -1, 0, 0, 0, 0);
    run_case("R11", 15, 15, 0, 0, 100, -1, 0, 0, 0, 0);
    run_case("R6", 1, 2, 5, 0, 40, -1, 0, 0, 0, 0);
    run_case("R6", 0, 1, 15, 0, 40, -1, 0, 0, 0, 0);
    run_case("R7", 2, 4, 3, 1, 50, -1, 0, 0, 0, 0);
    run_case("R7", 1, 15, 0, 1, 60, -1, 0, 0, 0, 0);
    run_case("R8", 2, 1, 2, 0, 50, 20, 2, 1, 9, 1);
    run_case("R9", 2, 2, 0, 0, 50, 13, 5, 0, 0, 0);
    run_case("R9", 4, 3, 1, 0, 60, 7, 0, 2, 1, 0);
    // R5: sync asserted in the middle of a high phase
    run_case("R5", 6, 6, 0, 0, 3, -1, 0, 0, 0, 0);
    run_case("R5", 1, 1, 0, 0, 12, -1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);

    // R10: bypass passes the input clock
    cfg_bypass = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk(clk_out, 1'b1, "R10");
      @(negedge clk); #1;
      chk(clk_out, 1'b0, "R10");
    end
    cfg_bypass = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule